// File: doc/BRIEF.md
# Miss Status Holding Register File

This block follows the cache-line misses that an in-order pipeline has left outstanding while its loads carry on without blocking. Each of its entries stands for one missing line. Per word of that line the entry records which architectural register, if any, is waiting for that word. A one-bit full/empty scoreboard covers every register. A load that misses is accepted here: its destination register is marked empty and the load leaves the pipeline. A later miss to a line that already has an entry joins that entry and does not start a second memory request. The decode stage sends its two source registers and its destination register. The block raises a stall while any of them is still empty, so the pipeline waits only when a value that has not arrived is actually needed.

When memory returns a line, the response names the entry it belongs to. A small state machine then walks the words of that entry and writes each waiting register through a single write-back port. Each register it writes is marked full, and the entry is released once the walk ends. The machine has three states. FS_IDLE waits for a fill. FS_SCAN visits one word per cycle in ascending order. FS_RELEASE frees the entry. The transitions run FS_IDLE to FS_SCAN on an accepted fill for a valid entry, FS_SCAN to FS_RELEASE after the last word, and FS_RELEASE to FS_IDLE unconditionally.

Top module: `miss_tracker`

## Requirements
- R1: After reset no entry is in use, every register reads full (dec_stall low), req_valid is low and fill_ready is high.
- R2: An accepted miss whose line matches no pending entry takes the lowest-numbered free entry. In the following cycle req_valid is high for exactly one cycle, with req_line equal to the miss line and req_idx equal to that entry.
- R3: An accepted miss whose line matches a pending entry records its register in that entry and raises no memory request.
- R4: An accepted miss marks its destination register empty. dec_stall is high while dec_src_a, dec_src_b or dec_dst names an empty register.
- R5: A miss that matches no entry while all entries are in use raises miss_stall and changes nothing.
- R6: A miss that matches an entry whose word is already waited on raises miss_stall and changes nothing.
- R7: A miss whose destination register is already empty raises miss_stall, even if a free entry exists.
- R8: A fill (fill_valid while fill_ready) for entry k starts a pass over words 0 to 7 in ascending order, one word per cycle, beginning the cycle after acceptance. For each waiting word, wb_valid is high with wb_reg set to the recorded register and wb_data set to fill_data bits [32w+31:32w]. That register reads full from the next cycle on. fill_ready stays low for the 8 scan cycles and one release cycle.
- R9: When the pass ends, the entry is freed and can be allocated again.
- R10: An entry whose fill pass is running accepts no merges. A miss to its line allocates a different free entry and issues a new request.
- R11: A fill naming an entry that is not in use is ignored: no write-back occurs and fill_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_line | input | 26 | Line address of the miss |
| miss_word | input | 3 | Word within the line |
| miss_dest | input | 5 | Destination register of the load |
| miss_stall | output | 1 | Miss cannot be accepted this cycle |
| req_valid | output | 1 | New line request to memory |
| req_line | output | 26 | Line address requested |
| req_idx | output | 2 | Entry the request belongs to |
| dec_src_a | input | 5 | First source register in decode |
| dec_src_b | input | 5 | Second source register in decode |
| dec_dst | input | 5 | Destination register in decode |
| dec_stall | output | 1 | Decode must hold |
| fill_valid | input | 1 | Line data returned by memory |
| fill_idx | input | 2 | Entry the returned line belongs to |
| fill_data | input | 256 | The eight returned words, word 0 in the low bits |
| fill_ready | output | 1 | A fill can be accepted |
| wb_valid | output | 1 | Register write-back this cycle |
| wb_reg | output | 5 | Register written |
| wb_data | output | 32 | Value written |

## Verification
Misses are driven as fresh lines, as merges into a pending line, as a repeat of a word already waited on, with an already-empty destination, and with the file full. Together these separate allocation, merging and each of the three stall causes. Fills are checked word by word against a queue of expected write-backs. This shows that only waiting words are written, in ascending word order, with the correct slice of the line. A miss issued during a running fill to that fill's own line shows that a draining entry takes no merges. A fill to an unused entry must produce no write-back at all. Decode queries on each of the three fields, issued before and after fills, confirm that the full/empty bits track both the set and the clear paths.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_SCAN    = 2'd1,
        FS_RELEASE = 2'd2
    } fill_state_e;

endpackage

// File: rtl/mshr_entry.sv
module mshr_entry #(
    parameter int LINE_W = 26,
    parameter int WORDS  = 8,
    parameter int REG_W  = 5,
    localparam int WI_W  = $clog2(WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_en,
    input  logic                   merge_en,
    input  logic                   clear_en,
    input  logic [LINE_W-1:0]      in_line,
    input  logic [WI_W-1:0]        in_word,
    input  logic [REG_W-1:0]       in_reg,
    output logic                   valid_o,
    output logic [LINE_W-1:0]      line_o,
    output logic [WORDS-1:0]       wait_o,
    output logic [WORDS*REG_W-1:0] regs_o
);

    logic                   valid_q;
    logic [LINE_W-1:0]      line_q;
    logic [WORDS-1:0]       wait_q;
    logic [WORDS*REG_W-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            line_q  <= '0;
            wait_q  <= '0;
            regs_q  <= '0;
        end else if (clear_en) begin
            valid_q <= 1'b0;
            wait_q  <= '0;
        end else if (alloc_en) begin
            valid_q <= 1'b1;
            line_q  <= in_line;
            wait_q  <= '0;
            wait_q[in_word] <= 1'b1;
            regs_q[int'(in_word)*REG_W +: REG_W] <= in_reg;
        end else if (merge_en) begin
            wait_q[in_word] <= 1'b1;
            regs_q[int'(in_word)*REG_W +: REG_W] <= in_reg;
        end
    end

    assign valid_o = valid_q;
    assign line_o  = line_q;
    assign wait_o  = wait_q;
    assign regs_o  = regs_q;

    // R6: a merge may only claim a word slot nobody waits on yet
    p_merge_free_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en |-> (valid_q && !wait_q[in_word]));

    // R2: allocation only lands on an unused entry
    p_alloc_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !valid_q);

endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
    parameter int NREGS = 32,
    localparam int REG_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_reg,
    input  logic [REG_W-1:0] q_a,
    input  logic [REG_W-1:0] q_b,
    input  logic [REG_W-1:0] q_c,
    input  logic [REG_W-1:0] q_m,
    output logic             emp_a,
    output logic             emp_b,
    output logic             emp_c,
    output logic             emp_m
);

    logic [NREGS-1:0] empty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= '0;
        end else begin
            if (clr_en) empty_q[clr_reg] <= 1'b0;
            if (set_en) empty_q[set_reg] <= 1'b1;
        end
    end

    assign emp_a = empty_q[q_a];
    assign emp_b = empty_q[q_b];
    assign emp_c = empty_q[q_c];
    assign emp_m = empty_q[q_m];

    // R8: a write-back always targets a register that is waiting
    p_wb_target_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> empty_q[clr_reg]);

    // R7: a register is never marked empty twice
    p_no_double_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !empty_q[set_reg]);

    // R4: an accepted miss leaves its destination empty next cycle
    p_set_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !(clr_en && clr_reg == set_reg)) |=> empty_q[$past(set_reg)]);

endmodule

// File: rtl/fill_fsm.sv
module fill_fsm
    import mshr_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 8,
    parameter int DATA_W  = 32,
    parameter int REG_W   = 5,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int WI_W   = $clog2(WORDS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fill_valid,
    input  logic [IDX_W-1:0]               fill_idx,
    input  logic [WORDS*DATA_W-1:0]        fill_data,
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic [ENTRIES*WORDS-1:0]       ent_wait,
    input  logic [ENTRIES*WORDS*REG_W-1:0] ent_regs,
    output logic                           fill_ready,
    output logic                           busy,
    output logic [IDX_W-1:0]               busy_idx,
    output logic [ENTRIES-1:0]             clear_vec,
    output logic                           wb_valid,
    output logic [REG_W-1:0]               wb_reg,
    output logic [DATA_W-1:0]              wb_data
);

    fill_state_e              state_q, state_d;
    logic [IDX_W-1:0]         idx_q;
    logic [WI_W-1:0]          word_q;
    logic [WORDS*DATA_W-1:0]  data_q;
    logic                     start;
    int                       slot;

    assign start = fill_valid && ent_valid[fill_idx];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:    if (start) state_d = FS_SCAN;
            FS_SCAN:    if (word_q == WI_W'(WORDS - 1)) state_d = FS_RELEASE;
            FS_RELEASE: state_d = FS_IDLE;
            default:    state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            idx_q   <= '0;
            word_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FS_IDLE && start) begin
                idx_q  <= fill_idx;
                word_q <= '0;
                data_q <= fill_data;
            end else if (state_q == FS_SCAN) begin
                word_q <= word_q + 1'b1;
            end
        end
    end

    always_comb begin
        slot       = int'(idx_q) * WORDS + int'(word_q);
        fill_ready = (state_q == FS_IDLE);
        busy       = (state_q != FS_IDLE);
        busy_idx   = idx_q;
        wb_valid   = (state_q == FS_SCAN) && ent_wait[slot];
        wb_reg     = ent_regs[slot*REG_W +: REG_W];
        wb_data    = data_q[int'(word_q)*DATA_W +: DATA_W];
        for (int i = 0; i < ENTRIES; i++)
            clear_vec[i] = (state_q == FS_RELEASE) && (idx_q == IDX_W'(i));
    end

    // R9: release lasts exactly one cycle and returns to idle
    p_release_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_RELEASE) |=> (state_q == FS_IDLE));

    // R8: write-backs happen only while the port refuses new fills
    p_wb_in_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !fill_ready);

    // R11: a pass only ever runs on an entry that is in use
    p_scan_valid_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_SCAN) |-> ent_valid[idx_q]);

endmodule

// File: rtl/miss_tracker.sv
module miss_tracker #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 8,
    parameter int DATA_W  = 32,
    parameter int NREGS   = 32,
    parameter int LINE_W  = 26,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int WI_W   = $clog2(WORDS),
    localparam int REG_W  = $clog2(NREGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_valid,
    input  logic [LINE_W-1:0]       miss_line,
    input  logic [WI_W-1:0]         miss_word,
    input  logic [REG_W-1:0]        miss_dest,
    output logic                    miss_stall,
    output logic                    req_valid,
    output logic [LINE_W-1:0]       req_line,
    output logic [IDX_W-1:0]        req_idx,
    input  logic [REG_W-1:0]        dec_src_a,
    input  logic [REG_W-1:0]        dec_src_b,
    input  logic [REG_W-1:0]        dec_dst,
    output logic                    dec_stall,
    input  logic                    fill_valid,
    input  logic [IDX_W-1:0]        fill_idx,
    input  logic [WORDS*DATA_W-1:0] fill_data,
    output logic                    fill_ready,
    output logic                    wb_valid,
    output logic [REG_W-1:0]        wb_reg,
    output logic [DATA_W-1:0]       wb_data
);

    logic [ENTRIES-1:0]             ent_valid;
    logic [LINE_W-1:0]              ent_line [ENTRIES];
    logic [ENTRIES*WORDS-1:0]       ent_wait;
    logic [ENTRIES*WORDS*REG_W-1:0] ent_regs;
    logic [ENTRIES-1:0]             alloc_vec, merge_vec, clear_vec;
    logic                           busy;
    logic [IDX_W-1:0]               busy_idx;

    logic                           hit_any, free_any, word_taken, accept;
    logic [IDX_W-1:0]               hit_idx, free_idx;
    logic                           emp_a, emp_b, emp_c, emp_m;

    logic                           req_valid_q;
    logic [LINE_W-1:0]              req_line_q;
    logic [IDX_W-1:0]               req_idx_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        mshr_entry #(.LINE_W(LINE_W), .WORDS(WORDS), .REG_W(REG_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_en (alloc_vec[g]),
            .merge_en (merge_vec[g]),
            .clear_en (clear_vec[g]),
            .in_line  (miss_line),
            .in_word  (miss_word),
            .in_reg   (miss_dest),
            .valid_o  (ent_valid[g]),
            .line_o   (ent_line[g]),
            .wait_o   (ent_wait[g*WORDS +: WORDS]),
            .regs_o   (ent_regs[g*WORDS*REG_W +: WORDS*REG_W])
        );
    end

    // Lookup: a draining entry is invisible to merging; lowest free entry wins.
    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ent_valid[i] && ent_line[i] == miss_line &&
                !(busy && busy_idx == IDX_W'(i))) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!ent_valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        word_taken = ent_wait[int'(hit_idx)*WORDS + int'(miss_word)];
        miss_stall = miss_valid &&
                     (emp_m || (hit_any ? word_taken : !free_any));
        accept     = miss_valid && !miss_stall;
        for (int i = 0; i < ENTRIES; i++) begin
            alloc_vec[i] = accept && !hit_any && (free_idx == IDX_W'(i));
            merge_vec[i] = accept &&  hit_any && (hit_idx  == IDX_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid_q <= 1'b0;
            req_line_q  <= '0;
            req_idx_q   <= '0;
        end else begin
            req_valid_q <= accept && !hit_any;
            if (accept && !hit_any) begin
                req_line_q <= miss_line;
                req_idx_q  <= free_idx;
            end
        end
    end

    assign req_valid = req_valid_q;
    assign req_line  = req_line_q;
    assign req_idx   = req_idx_q;

    reg_scoreboard #(.NREGS(NREGS)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (accept),
        .set_reg (miss_dest),
        .clr_en  (wb_valid),
        .clr_reg (wb_reg),
        .q_a     (dec_src_a),
        .q_b     (dec_src_b),
        .q_c     (dec_dst),
        .q_m     (miss_dest),
        .emp_a   (emp_a),
        .emp_b   (emp_b),
        .emp_c   (emp_c),
        .emp_m   (emp_m)
    );

    assign dec_stall = emp_a || emp_b || emp_c;

    fill_fsm #(.ENTRIES(ENTRIES), .WORDS(WORDS), .DATA_W(DATA_W), .REG_W(REG_W)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_valid (fill_valid),
        .fill_idx   (fill_idx),
        .fill_data  (fill_data),
        .ent_valid  (ent_valid),
        .ent_wait   (ent_wait),
        .ent_regs   (ent_regs),
        .fill_ready (fill_ready),
        .busy       (busy),
        .busy_idx   (busy_idx),
        .clear_vec  (clear_vec),
        .wb_valid   (wb_valid),
        .wb_reg     (wb_reg),
        .wb_data    (wb_data)
    );

    // R7: an empty destination register always blocks the miss
    p_stall_empty_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && emp_m) |-> miss_stall);

    // R5: a full file with no matching line never accepts a miss
    p_stall_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && (&ent_valid) && !hit_any) |-> miss_stall);

    // R2: at most one entry is claimed per cycle
    p_single_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec | merge_vec));

    // R10: the entry being drained is never merged into
    p_no_merge_draining_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !merge_vec[busy_idx]);

endmodule

// File: tb/sim_miss_tracker.sv
module sim_miss_tracker;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic [25:0]  miss_line = '0;
    logic [2:0]   miss_word = '0;
    logic [4:0]   miss_dest = '0;
    logic         miss_stall;
    logic         req_valid;
    logic [25:0]  req_line;
    logic [1:0]   req_idx;
    logic [4:0]   dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
    logic         dec_stall;
    logic         fill_valid = 1'b0;
    logic [1:0]   fill_idx = '0;
    logic [255:0] fill_data = '0;
    logic         fill_ready;
    logic         wb_valid;
    logic [4:0]   wb_reg;
    logic [31:0]  wb_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [36:0] exp_q [$];

    always #4 clk = ~clk;

    miss_tracker u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] wordval(input int idx, input int w);
        return 32'hC0DE_0000 | (idx << 8) | w;
    endfunction

    function automatic logic [255:0] linedata(input int idx);
        logic [255:0] d;
        for (int w = 0; w < 8; w++) d[w*32 +: 32] = wordval(idx, w);
        return d;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8/R11 unexpected write-back", {27'd0, wb_reg, wb_data}, 64'd0);
            end else begin
                logic [36:0] e;
                e = exp_q.pop_front();
                chk({wb_reg, wb_data} == e, "R8 write-back reg/data", {27'd0, wb_reg, wb_data}, {27'd0, e});
            end
        end
    end

    task automatic do_miss(input logic [25:0] line, input logic [2:0] w, input logic [4:0] d,
                           output bit st, output bit rv, output logic [1:0] ri, output logic [25:0] rl);
        @(negedge clk);
        miss_valid = 1'b1; miss_line = line; miss_word = w; miss_dest = d;
        #1 st = miss_stall;
        @(negedge clk);
        rv = req_valid; ri = req_idx; rl = req_line;
        miss_valid = 1'b0;
    endtask

    task automatic dec_query(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c, output bit s);
        @(negedge clk);
        dec_src_a = a; dec_src_b = b; dec_dst = c;
        #1 s = dec_stall;
    endtask

    task automatic do_fill(input int idx);
        @(negedge clk);
        fill_valid = 1'b1; fill_idx = 2'(idx); fill_data = linedata(idx);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        bit st, rv, s;
        logic [1:0] ri;
        logic [25:0] rl;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
        chk(fill_ready == 1'b1, "R1 fill_ready", fill_ready, 1);
        dec_query(5'd5, 5'd7, 5'd10, s);
        chk(s == 1'b0, "R1 dec_stall", s, 0);

        // R2 fresh line to entry 0
        do_miss(26'h100, 3'd2, 5'd5, st, rv, ri, rl);
        chk(st == 1'b0, "R2 miss accepted", st, 0);
        chk(rv && ri == 2'd0 && rl == 26'h100, "R2 request", {rv, ri, rl}, {1'b1, 2'd0, 26'h100});
        // R4 src_a, src_b, dst each see empty
        dec_query(5'd5, 5'd1, 5'd2, s);
        chk(s == 1'b1, "R4 src_a empty", s, 1);
        dec_query(5'd1, 5'd5, 5'd2, s);
        chk(s == 1'b1, "R4 src_b empty", s, 1);
        dec_query(5'd1, 5'd2, 5'd5, s);
        chk(s == 1'b1, "R4 dst empty", s, 1);

        // R3 merge into entry 0
        do_miss(26'h100, 3'd6, 5'd7, st, rv, ri, rl);
        chk(st == 1'b0 && rv == 1'b0, "R3 merge no request", {st, rv}, 2'b00);

        // R6 word already waited on
        do_miss(26'h100, 3'd2, 5'd9, st, rv, ri, rl);
        chk(st == 1'b1 && rv == 1'b0, "R6 same word stalls", {st, rv}, 2'b10);
        dec_query(5'd9, 5'd9, 5'd9, s);
        chk(s == 1'b0, "R6 dest untouched", s, 0);

        // R7 empty destination
        do_miss(26'h200, 3'd0, 5'd5, st, rv, ri, rl);
        chk(st == 1'b1 && rv == 1'b0, "R7 empty dest stalls", {st, rv}, 2'b10);

        // fill remaining entries
        do_miss(26'h200, 3'd0, 5'd10, st, rv, ri, rl);
        chk(!st && rv && ri == 2'd1, "R2 second entry", {st, rv, ri}, {1'b0, 1'b1, 2'd1});
        do_miss(26'h300, 3'd3, 5'd11, st, rv, ri, rl);
        chk(!st && rv && ri == 2'd2, "R2 third entry", {st, rv, ri}, {1'b0, 1'b1, 2'd2});
        do_miss(26'h400, 3'd7, 5'd12, st, rv, ri, rl);
        chk(!st && rv && ri == 2'd3, "R2 fourth entry", {st, rv, ri}, {1'b0, 1'b1, 2'd3});

        // R5 no free, no match
        do_miss(26'h500, 3'd1, 5'd13, st, rv, ri, rl);
        chk(st == 1'b1 && rv == 1'b0, "R5 full stalls", {st, rv}, 2'b10);
        dec_query(5'd13, 5'd0, 5'd0, s);
        chk(s == 1'b0, "R5 dest untouched", s, 0);

        // R8 fill entry 0: words 2 then 6
        exp_q.push_back({5'd5, wordval(0, 2)});
        exp_q.push_back({5'd7, wordval(0, 6)});
        do_fill(0);
        chk(fill_ready == 1'b0, "R8 fill_ready low in pass", fill_ready, 0);
        repeat (9) @(negedge clk);
        chk(fill_ready == 1'b1, "R8 fill_ready back after release", fill_ready, 1);
        chk(exp_q.size() == 0, "R8 all words written", exp_q.size(), 0);
        dec_query(5'd5, 5'd7, 5'd0, s);
        chk(s == 1'b0, "R8 registers full", s, 0);

        // R10 miss to a draining line allocates a new entry
        exp_q.push_back({5'd10, wordval(1, 0)});
        @(negedge clk);
        fill_valid = 1'b1; fill_idx = 2'd1; fill_data = linedata(1);
        @(negedge clk);
        fill_valid = 1'b0;
        miss_valid = 1'b1; miss_line = 26'h200; miss_word = 3'd4; miss_dest = 5'd14;
        #1 st = miss_stall;
        @(negedge clk);
        rv = req_valid; ri = req_idx; rl = req_line;
        miss_valid = 1'b0;
        chk(!st && rv && ri == 2'd0 && rl == 26'h200, "R10 no merge while draining",
            {st, rv, ri, rl}, {1'b0, 1'b1, 2'd0, 26'h200});
        repeat (10) @(negedge clk);

        // R9 entry 1 freed and reused
        do_miss(26'h600, 3'd1, 5'd15, st, rv, ri, rl);
        chk(!st && rv && ri == 2'd1 && rl == 26'h600, "R9 freed entry reused",
            {st, rv, ri, rl}, {1'b0, 1'b1, 2'd1, 26'h600});

        // R8 fill entry 2, then R11 fill to the now unused entry 2
        exp_q.push_back({5'd11, wordval(2, 3)});
        do_fill(2);
        repeat (10) @(negedge clk);
        do_fill(2);
        chk(fill_ready == 1'b1, "R11 unused entry fill ignored", fill_ready, 1);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R11 no extra write-back", exp_q.size(), 0);
        dec_query(5'd11, 5'd14, 5'd0, s);
        chk(s == 1'b1, "R4 pending reg 14 still empty", s, 1);

        finish_run();
    end

endmodule